// File: doc/BRIEF.md
# Programmable Interval Timer

The block is a down-counting periodic timer that software drives through a small synchronous register bus. A free-running tick enable, arriving at half the system clock rate, is divided by a power-of-two prescaler. Each divided tick decrements a counter. When the counter passes through zero it reloads its limit on the same tick and raises a status flag. A level interrupt follows that flag while interrupts are enabled.

Software programs a modulus word and a control word, and can read back the live count. Control writes that only change the interrupt-enable bit or clear the flag leave the counting undisturbed. Every other control write restarts the counting from the limit. An immediate-load option makes a modulus write take effect at once. Without that option, the new modulus takes effect at the next expiry.

Top module: `pit_timer`

## Requirements
- R1: After a synchronous active-low reset, the control word, modulus and count all read 0 and `irq` is low. Register offsets are: control 0, modulus 2, count 4. Any other offset reads 0.
- R2: While the enable bit (control bit 0) is 1, the count drops by one on every 2^E-th tick-enable cycle, where E is the prescale exponent in control bits 11:8 (E = 0..15). The prescaler phase starts at zero on every restart.
- R3: With the wrap-at-max bit (control bit 1) at 0, a step taken at count 0 loads the modulus on that same step, so one period is modulus+1 steps. That step also sets the flag (control bit 2).
- R4: With the wrap-at-max bit at 1, the limit is 0xFFFF in place of the modulus, both for restarts and for expiry reloads.
- R5: `irq` is 1 exactly when the flag is 1 and the interrupt-enable bit (control bit 3) is 1.
- R6: A control write with bit 2 at 1 clears the flag. A write with bit 2 at 0 leaves the flag unchanged. No write sets the flag.
- R7: A control write is quiet when it differs from the stored word only in bit 3 or bit 2. A quiet write leaves the count and the prescaler phase untouched.
- R8: A control write that is not quiet stores the new word, loads the count with the limit chosen by the new wrap-at-max bit, and resets the prescaler. While enable is 0, the count holds.
- R9: A modulus write clears the flag. With the immediate-load bit (control bit 4) at 1, the same write loads the count with the new limit.
- R10: With the immediate-load bit at 0, a modulus write leaves the running count alone, and the new value is first used at the next expiry reload.
- R11: Writes to the count offset change nothing.
- R12: When an expiry and a flag-clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick enable, one pulse per timer tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit data path and a 4-bit prescale exponent. With these values the largest exponent, 15, is reachable. One count step then takes 65,536 clock cycles, so the bench covers the top of the divider range and not only small ratios. The 16-bit width also places the wrap-at-max limit at 0xFFFF. A modulus of 0 gives one expiry per step, and bursts of flag-clearing writes then land on expiry cycles. This brings the set-versus-clear collision within reach.

// File: rtl/pit_pkg.sv
// Package pit_pkg
// Shared constants for the interval timer: control-word bit positions
// and register offsets. Bit positions are fixed because software decodes them.
package pit_pkg;
    localparam int CTL_EN    = 0;   // counting enable
    localparam int CTL_WRAP  = 1;   // limit is all-ones instead of modulus
    localparam int CTL_FLAG  = 2;   // expiry flag (write one to clear)
    localparam int CTL_IE    = 3;   // interrupt enable
    localparam int CTL_IMM   = 4;   // modulus write loads count at once
    localparam int CTL_HALT  = 5;   // stored only
    localparam int CTL_SLEEP = 6;   // stored only
    localparam int PRE_LSB   = 8;   // prescale exponent field low bit
    localparam int PRE_W     = 4;   // prescale exponent field width

    localparam int OFS_CTL = 0;
    localparam int OFS_MOD = 2;
    localparam int OFS_CNT = 4;
endpackage

// File: rtl/pit_regs.sv
// Module pit_regs
// Holds the control word, the modulus and the expiry flag, and decodes writes.
// It tells quiet control writes (interrupt-enable and flag-clear only) apart
// from restarting ones, and works out when and with what value the counter loads.
// Assumes: addr is a byte offset, and a write is a single-cycle wr_en pulse per word.
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] modulus_q,
    output logic              flag_q,
    output logic              restart,
    output logic              load_stb,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] reload_lim
);
    localparam logic [DATA_W-1:0] PRE_FIELD  = DATA_W'(((1 << PRE_W) - 1) << PRE_LSB);
    localparam logic [DATA_W-1:0] STORE_MASK = PRE_FIELD
                                             | (DATA_W'(1) << CTL_EN)
                                             | (DATA_W'(1) << CTL_WRAP)
                                             | (DATA_W'(1) << CTL_IE)
                                             | (DATA_W'(1) << CTL_IMM)
                                             | (DATA_W'(1) << CTL_HALT)
                                             | (DATA_W'(1) << CTL_SLEEP);
    localparam logic [DATA_W-1:0] RUN_MASK   = STORE_MASK & ~(DATA_W'(1) << CTL_IE);

    logic sel_ctl;
    logic sel_mod;
    logic quiet;

    // Decode which register the current write targets.
    always_comb begin
        sel_ctl = wr_en && (addr == ADDR_W'(OFS_CTL));
        sel_mod = wr_en && (addr == ADDR_W'(OFS_MOD));
    end

    // Classify control writes and pick the counter load value.
    always_comb begin
        quiet      = ((wdata ^ ctrl_q) & RUN_MASK) == '0;
        restart    = sel_ctl && !quiet;
        reload_lim = ctrl_q[CTL_WRAP] ? '1 : modulus_q;
        load_stb   = restart || (sel_mod && ctrl_q[CTL_IMM]);
        if (restart) begin
            load_val = wdata[CTL_WRAP] ? '1 : modulus_q;
        end else begin
            load_val = ctrl_q[CTL_WRAP] ? '1 : wdata;
        end
    end

    // Control word storage, implemented bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (sel_ctl) begin
            ctrl_q <= wdata & STORE_MASK;
        end
    end

    // Modulus storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modulus_q <= '0;
        end else if (sel_mod) begin
            modulus_q <= wdata;
        end
    end

    // Expiry flag: hardware set wins over any clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if ((sel_ctl && wdata[CTL_FLAG]) || sel_mod) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pit_prescale.sv
// Module pit_prescale
// Divides the tick enable by 2^exp_sel and emits a one-cycle step strobe.
// Assumes: clear returns the phase to zero, and run gates both counting and stepping.
module pit_prescale #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clear,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             step
);
    localparam int DIV_W = (1 << EXP_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] term;

    // Terminal phase is 2^exp_sel - 1: one set bit per exponent unit.
    for (genvar g = 0; g < DIV_W; g++) begin : g_term
        assign term[g] = (exp_sel > EXP_W'(g));
    end

    // Step when the phase reaches its terminal value on a tick.
    always_comb step = run && tick && (phase_q == term);

    // Phase counter advance and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (run && tick) begin
            phase_q <= step ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/pit_downcnt.sv
// Module pit_downcnt
// Down counter that reloads its limit on the step taken at zero and flags expiry.
// Assumes: load has priority over step, and a loading cycle never reports expiry.
module pit_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [W-1:0] reload_lim,
    output logic [W-1:0] cnt_q,
    output logic         expire
);
    // Expiry is a step taken at zero that no load overrides.
    always_comb expire = step && !load && (cnt_q == '0);

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= (cnt_q == '0) ? reload_lim : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/pit_timer.sv
// Module pit_timer
// Top of the interval timer: register file, prescaler and down counter,
// plus a combinational read mux and the level interrupt.
// Assumes: tick_en is a clock enable synchronous to clk, and reads have no side effects.
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] modulus_q;
    logic              flag_q;
    logic              restart;
    logic              load_stb;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] reload_lim;
    logic              step;
    logic              expire;
    logic [DATA_W-1:0] cnt_q;
    logic              run_en;
    logic              wrap_en;
    logic              ie_en;

    // Named control fields used by the datapath and the checker.
    always_comb begin
        run_en  = ctrl_q[CTL_EN];
        wrap_en = ctrl_q[CTL_WRAP];
        ie_en   = ctrl_q[CTL_IE];
    end

    pit_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .expire     (expire),
        .ctrl_q     (ctrl_q),
        .modulus_q  (modulus_q),
        .flag_q     (flag_q),
        .restart    (restart),
        .load_stb   (load_stb),
        .load_val   (load_val),
        .reload_lim (reload_lim)
    );

    pit_prescale #(
        .EXP_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_en),
        .tick    (tick_en),
        .clear   (restart),
        .exp_sel (ctrl_q[PRE_LSB +: PRE_W]),
        .step    (step)
    );

    pit_downcnt #(
        .W (DATA_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_stb),
        .load_val   (load_val),
        .step       (step),
        .reload_lim (reload_lim),
        .cnt_q      (cnt_q),
        .expire     (expire)
    );

    // Read mux by byte offset.
    always_comb begin
        case (addr)
            ADDR_W'(OFS_CTL): rdata = ctrl_q | (DATA_W'(flag_q) << CTL_FLAG);
            ADDR_W'(OFS_MOD): rdata = modulus_q;
            ADDR_W'(OFS_CNT): rdata = cnt_q;
            default:          rdata = '0;
        endcase
    end

    // Level interrupt from flag and enable.
    always_comb irq = flag_q && ie_en;
endmodule

// File: rtl/pit_timer_chk.sv
// Module pit_timer_chk
// Temporal checks on the timer, attached to pit_timer through bind.
// Assumes: internal step, load and count signals are reachable by name in pit_timer.
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              step,
    input logic              load,
    input logic [DATA_W-1:0] cnt,
    input logic              flag,
    input logic              en,
    input logic              wrap,
    input logic              ie
);
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
    AST_WRAP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt == '0 && wrap) |=> (cnt == {DATA_W{1'b1}})); // R4
    AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt == '0) |=> flag); // R12
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_en) |=> $stable(cnt)); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie); // R5
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CTL) && wdata[CTL_FLAG]
         && !(step && !load && cnt == '0)) |=> !flag); // R6
    AST_RO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CNT) && !step) |=> $stable(cnt)); // R11
endmodule

bind pit_timer pit_timer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .irq   (irq),
    .step  (step),
    .load  (load_stb),
    .cnt   (cnt_q),
    .flag  (flag_q),
    .en    (run_en),
    .wrap  (wrap_en),
    .ie    (ie_en)
);

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
// Bench for pit_timer: a behavioural reference model, updated on every
// rising edge, is compared with rdata and irq on every falling edge.
module tb_pit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_ctrl = 0, m_flag = 0, m_mod = 0, m_cnt = 0, m_pcnt = 0;

    pit_timer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq)
    );

    always #2 clk = ~clk;

    // tick enable at half the clock rate
    always @(posedge clk) begin
        #1;
        tick_en <= ~tick_en;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // reference model, built from the requirements
    always @(posedge clk) begin
        int pre, en, wrap, imm, lim, lv, nctrl;
        bit wctl, wmod, restart, stp, load, expd;
        started = 1;
        if (!rst_n) begin
            m_ctrl = 0; m_flag = 0; m_mod = 0; m_cnt = 0; m_pcnt = 0;
        end else begin
            pre  = (m_ctrl >> 8) & 15;
            en   = m_ctrl & 1;
            wrap = (m_ctrl >> 1) & 1;
            imm  = (m_ctrl >> 4) & 1;
            wctl = wr_en && addr == 0;
            wmod = wr_en && addr == 2;
            restart = wctl && (((int'(wdata) ^ m_ctrl) & 'h0F73) != 0);
            stp = en && tick_en && (m_pcnt == (1 << pre) - 1);
            nctrl = wctl ? (int'(wdata) & 'h0F7B) : m_ctrl;
            lim = wrap ? 65535 : m_mod;
            load = 0; lv = 0;
            if (restart) begin
                load = 1; lv = ((nctrl >> 1) & 1) ? 65535 : m_mod;
            end else if (wmod && imm) begin
                load = 1; lv = wrap ? 65535 : int'(wdata);
            end
            expd = stp && !load && m_cnt == 0;
            if (load) m_cnt = lv;
            else if (stp) m_cnt = (m_cnt == 0) ? lim : m_cnt - 1;
            if (restart) m_pcnt = 0;
            else if (en && tick_en) m_pcnt = stp ? 0 : m_pcnt + 1;
            if (expd) m_flag = 1;
            else if ((wctl && wdata[2]) || wmod) m_flag = 0;
            if (wmod) m_mod = int'(wdata);
            m_ctrl = nctrl;
        end
    end

    // compare with the model away from the active edge
    always @(negedge clk) begin
        int exp_rd;
        if (started && !done) begin
            case (addr)
                3'd0: exp_rd = m_ctrl | (m_flag << 2);
                3'd2: exp_rd = m_mod;
                3'd4: exp_rd = m_cnt;
                default: exp_rd = 0;
            endcase
            chk(cur_req, "rdata", {16'd0, rdata}, exp_rd);
            chk("R5", "irq", {31'd0, irq}, m_flag & ((m_ctrl >> 3) & 1));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr_burst(input logic [2:0] a, input logic [15:0] d, input int n);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        repeat (n) @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic sel(input logic [2:0] a);
        @(posedge clk); #1;
        addr = a;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        sel(3'd2); sel(3'd4); sel(3'd6);
        @(posedge clk); #1; rst_n = 1'b1;
        sel(3'd0); sel(3'd2); sel(3'd4);

        cur_req = "R3";
        wr(3'd2, 16'd5);
        wr(3'd0, 16'h0001);
        sel(3'd4); repeat (30) @(posedge clk);
        sel(3'd0); repeat (3) @(posedge clk);

        cur_req = "R5";
        wr(3'd0, 16'h0009);
        repeat (6) @(posedge clk);

        cur_req = "R7";
        sel(3'd4); repeat (3) @(posedge clk);
        wr(3'd0, 16'h0001);
        repeat (10) @(posedge clk);
        wr(3'd0, 16'h0009);
        repeat (5) @(posedge clk);

        cur_req = "R6";
        wr(3'd0, 16'h0009);
        sel(3'd0);
        wr(3'd0, 16'h000D);
        repeat (2) @(posedge clk);

        cur_req = "R12";
        wr(3'd2, 16'd0);
        repeat (20) @(posedge clk);
        wr_burst(3'd0, 16'h000D, 7);
        repeat (4) @(posedge clk);

        cur_req = "R8";
        wr(3'd2, 16'd20);
        wr(3'd0, 16'h0301);
        sel(3'd4); repeat (200) @(posedge clk);
        wr(3'd0, 16'h0300);
        repeat (20) @(posedge clk);

        cur_req = "R2";
        wr(3'd0, 16'h0F01);
        repeat (66000) @(posedge clk);

        cur_req = "R4";
        wr(3'd0, 16'h0003);
        repeat (50) @(posedge clk);

        cur_req = "R9";
        wr(3'd0, 16'h0013);
        wr(3'd2, 16'd100);
        sel(3'd4); repeat (5) @(posedge clk);
        wr(3'd0, 16'h0011);
        wr(3'd2, 16'd7);
        sel(3'd4); repeat (30) @(posedge clk);

        cur_req = "R10";
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'd3);
        sel(3'd4); repeat (40) @(posedge clk);

        cur_req = "R11";
        wr(3'd4, 16'h1234);
        repeat (5) @(posedge clk);
        sel(3'd0); repeat (2) @(posedge clk);

        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule